// File: doc/BRIEF.md
# Dual Four-Bit Addressable Latch With Clear

This block stores two independent four-bit banks, called a and b, that share one set of controls: a two-bit select address, an active-low write enable and an active-low clear. Each bank has its own single data input and presents its four stored bits as a parallel vector. Together, the clear and enable inputs pick one of four modes. In clear-all mode every stored bit goes to zero. In demultiplex mode each bank drives its data bit onto the addressed position and zeroes the other positions. In addressable-write mode only the addressed bit is updated. In hold mode all bits are kept.

The block is fully synchronous. It samples its inputs on the rising clock edge, and each output reflects the mode sampled at the previous edge. A typical use is serial-to-parallel loading: the address steps through positions in hold mode, then enable is pulsed low for one cycle to write the chosen bit. Changing the address while the block can be written is a usage error. The block therefore raises a one-cycle violation pulse whenever the address moves while enable is low.

Top module: `dual_addr_latch`

## Requirements
- R1: A rising edge with `rst_n` low makes both banks all zero and `addr_viol` zero.
- R2: An edge sampling `clr_n`=0 and `en_n`=1 (clear-all mode) makes all eight stored bits zero.
- R3: An edge sampling `clr_n`=1 and `en_n`=0 (write mode) loads each bank's data input into bit n, where n is the unsigned value of `sel_addr` with `sel_addr[0]` as least significant bit.
- R4: In write mode, the three bits not selected by `sel_addr` keep their previous values in both banks.
- R5: An edge sampling `clr_n`=0 and `en_n`=0 (demultiplex mode) sets bit n of each bank to that bank's data input and all other bits of that bank to zero.
- R6: An edge sampling `clr_n`=1 and `en_n`=1 (hold mode) leaves all eight bits unchanged, whatever the data inputs and address.
- R7: Bank a takes its data only from `din_a` and bank b only from `din_b`, so the two banks can hold different patterns.
- R8: `addr_viol` is high for exactly the cycle after an edge at which `en_n` was 0 and `sel_addr` differed from its value at the previous non-reset edge.
- R9: `addr_viol` stays low after an address change made with `en_n`=1, and after the first edge following reset.
- R10: Every output change appears one clock edge after the inputs that cause it are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_addr | input | 2 | Bit position selected in both banks |
| en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low clear |
| din_a | input | 1 | Data bit for bank a |
| din_b | input | 1 | Data bit for bank b |
| bank_a | output | 4 | Stored bits of bank a |
| bank_b | output | 4 | Stored bits of bank b |
| addr_viol | output | 1 | One-cycle pulse for an address change while writable |

## Verification
The outputs are the stored state itself, so a wrong bit in either bank appears on `bank_a` or `bank_b` at the first edge after it is written. It then stays visible through every hold cycle that follows. A bit corrupted in the previous-address register shows up only on `addr_viol`, one cycle after the next edge sampled with enable low. The stimulus therefore mixes long hold stretches with address moves made both inside and outside the writable modes.

// File: rtl/dal_pkg.sv
// Package dal_pkg
// Shared mode type for the dual addressable latch.
// Assumes the clear and enable controls are both active low.
package dal_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_DEMUX = 2'd1,
        MODE_WRITE = 2'd2,
        MODE_HOLD  = 2'd3
    } dal_mode_e;

    // Maps the two active-low controls onto an operating mode.
    function automatic dal_mode_e decode_mode(input logic clr_n, input logic en_n);
        dal_mode_e m;
        case ({clr_n, en_n})
            2'b01:   m = MODE_CLEAR;
            2'b00:   m = MODE_DEMUX;
            2'b10:   m = MODE_WRITE;
            default: m = MODE_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dal_mode_dec.sv
// Module dal_mode_dec
// Combinational decode of the clear/enable pair into one mode.
// Assumes the inputs are already synchronous to the block clock.
module dal_mode_dec
    import dal_pkg::*;
(
    input  logic      clr_n,
    input  logic      en_n,
    output dal_mode_e mode
);

    // Decode the control pair.
    always_comb begin
        mode = decode_mode(clr_n, en_n);
    end

endmodule

// File: rtl/dal_bank.sv
// Module dal_bank
// One bank of 2**ADDR_W stored bits, updated at each rising edge
// according to the decoded mode. Assumes the mode and the address
// are held steady around the clock edge.
module dal_bank
    import dal_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  dal_mode_e            mode,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 din,
    output logic [(1<<ADDR_W)-1:0] q
);

    localparam int BITS = 1 << ADDR_W;

    logic [BITS-1:0] q_r;
    logic [BITS-1:0] q_nxt;
    logic [BITS-1:0] sel_hot;

    // One-hot select vector for the addressed bit.
    always_comb begin
        sel_hot = '0;
        sel_hot[addr] = 1'b1;
    end

    // Next-state selection per mode.
    always_comb begin
        case (mode)
            MODE_CLEAR: q_nxt = '0;
            MODE_DEMUX: q_nxt = din ? sel_hot : '0;
            MODE_WRITE: q_nxt = din ? (q_r | sel_hot) : (q_r & ~sel_hot);
            default:    q_nxt = q_r;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
    end

    assign q = q_r;

endmodule

// File: rtl/dal_addr_watch.sv
// Module dal_addr_watch
// Flags an address change sampled while enable is low. The first
// edge after reset has no previous address and never flags.
module dal_addr_watch #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              viol
);

    logic [ADDR_W-1:0] prev_addr;
    logic              prev_ok;
    logic              viol_r;

    // Track the last sampled address and raise the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr <= '0;
            prev_ok   <= 1'b0;
            viol_r    <= 1'b0;
        end else begin
            prev_addr <= addr;
            prev_ok   <= 1'b1;
            viol_r    <= prev_ok && !en_n && (addr != prev_addr);
        end
    end

    assign viol = viol_r;

endmodule

// File: rtl/dual_addr_latch.sv
// Module dual_addr_latch
// Two addressable banks that share address, enable and clear.
// Assumes the address changes only in hold mode; otherwise it
// raises addr_viol for one cycle.
module dual_addr_latch
    import dal_pkg::*;
#(
    parameter int ADDR_W = 2,
    localparam int BITS  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              en_n,
    input  logic              clr_n,
    input  logic              din_a,
    input  logic              din_b,
    output logic [BITS-1:0]   bank_a,
    output logic [BITS-1:0]   bank_b,
    output logic              addr_viol
);

    localparam int NBANK = 2;

    dal_mode_e         mode;
    logic [NBANK-1:0]  din_v;
    logic [BITS-1:0]   q_v [NBANK];

    assign din_v = {din_b, din_a};

    dal_mode_dec u_dec (
        .clr_n (clr_n),
        .en_n  (en_n),
        .mode  (mode)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        dal_bank #(.ADDR_W(ADDR_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .addr  (sel_addr),
            .din   (din_v[g]),
            .q     (q_v[g])
        );
    end

    dal_addr_watch #(.ADDR_W(ADDR_W)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .en_n  (en_n),
        .addr  (sel_addr),
        .viol  (addr_viol)
    );

    assign bank_a = q_v[0];
    assign bank_b = q_v[1];

endmodule

// File: rtl/dal_chk.sv
// Module dal_chk
// Port-level properties for dual_addr_latch, attached by bind.
module dal_chk #(
    parameter int ADDR_W = 2,
    localparam int BITS  = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sel_addr,
    input logic              en_n,
    input logic              clr_n,
    input logic              din_a,
    input logic              din_b,
    input logic [BITS-1:0]   bank_a,
    input logic [BITS-1:0]   bank_b,
    input logic              addr_viol
);

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && en_n) |=> (bank_a == '0 && bank_b == '0));

    // R3
    write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !en_n) |=> (bank_a[$past(sel_addr)] == $past(din_a)
                              && bank_b[$past(sel_addr)] == $past(din_b)));

    // R5
    demux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && !en_n) |=> ($onehot0(bank_a) && $onehot0(bank_b)));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && en_n) |=> ($stable(bank_a) && $stable(bank_b)));

    // R8
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_viol |-> $past(!en_n));

endmodule

bind dual_addr_latch dal_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_addr  (sel_addr),
    .en_n      (en_n),
    .clr_n     (clr_n),
    .din_a     (din_a),
    .din_b     (din_b),
    .bank_a    (bank_a),
    .bank_b    (bank_b),
    .addr_viol (addr_viol)
);

// File: tb/dual_addr_latch_bench.sv
`timescale 1ns/1ps
module dual_addr_latch_bench;

    typedef struct {
        logic [3:0] ea;
        logic [3:0] eb;
        logic       ev;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_addr = 2'd0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic       din_a = 1'b0;
    logic       din_b = 1'b0;
    logic [3:0] bank_a, bank_b;
    logic       addr_viol;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;
    exp_t q_exp[$];

    logic [3:0] ma = '0, mb = '0;
    logic [1:0] m_prev = '0;
    logic       m_ok = 1'b0;

    always #2.5 clk = ~clk;

    dual_addr_latch u_dual_addr_latch (
        .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .en_n(en_n),
        .clr_n(clr_n), .din_a(din_a), .din_b(din_b),
        .bank_a(bank_a), .bank_b(bank_b), .addr_viol(addr_viol)
    );

    // Driver: apply inputs at a falling edge and queue the expected result.
    task automatic step(input logic r, input logic [1:0] ad, input logic e,
                        input logic c, input logic da, input logic db,
                        input string tag);
        exp_t x;
        logic v;
        @(negedge clk);
        rst_n = r; sel_addr = ad; en_n = e; clr_n = c; din_a = da; din_b = db;
        if (!r) begin
            ma = '0; mb = '0; m_prev = '0; m_ok = 1'b0; v = 1'b0;
        end else begin
            v = m_ok && !e && (ad != m_prev);
            case ({c, e})
                2'b01: begin ma = '0; mb = '0; end
                2'b00: begin ma = '0; mb = '0; ma[ad] = da; mb[ad] = db; end
                2'b10: begin ma[ad] = da; mb[ad] = db; end
                default: ;
            endcase
            m_prev = ad; m_ok = 1'b1;
        end
        x.ea = ma; x.eb = mb; x.ev = v; x.tag = tag;
        q_exp.push_back(x);
    endtask

    // Monitor: compare each result shortly after the edge that produces it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                exp_t x;
                x = q_exp.pop_front();
                n_chk++;
                if (bank_a !== x.ea || bank_b !== x.eb || addr_viol !== x.ev) begin
                    n_err++;
                    $display("FAIL %s: got a=%b b=%b viol=%b, expected a=%b b=%b viol=%b",
                             x.tag, bank_a, bank_b, addr_viol, x.ea, x.eb, x.ev);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        step(0, 2'd0, 1, 1, 1, 1, "R1 reset");
        step(0, 2'd3, 0, 1, 1, 1, "R1 reset with write inputs");
        step(1, 2'd0, 1, 1, 1, 0, "R6 hold after reset, R9 first edge");
        step(1, 2'd0, 0, 1, 1, 0, "R3 write addr0 R10");
        step(1, 2'd2, 1, 1, 0, 0, "R9 address move in hold");
        step(1, 2'd2, 0, 1, 0, 1, "R3 R7 write addr2");
        step(1, 2'd3, 1, 1, 0, 0, "R9 hold move");
        step(1, 2'd3, 0, 1, 1, 1, "R3 R4 write addr3");
        step(1, 2'd3, 1, 1, 0, 0, "R6 hold din ignored");
        step(1, 2'd1, 1, 1, 1, 1, "R6 hold address ignored");
        step(1, 2'd1, 0, 1, 0, 1, "R4 R7 write addr1");
        step(1, 2'd0, 0, 1, 0, 0, "R8 viol on write move");
        step(1, 2'd0, 1, 1, 1, 1, "R8 pulse ends");
        step(1, 2'd0, 1, 0, 1, 1, "R2 clear all");
        step(1, 2'd0, 1, 1, 0, 0, "R6 hold zeros");
        step(1, 2'd2, 1, 1, 0, 0, "R9 move in hold");
        step(1, 2'd2, 0, 0, 1, 0, "R5 demux addr2");
        step(1, 2'd2, 0, 0, 0, 1, "R5 R7 demux swap");
        step(1, 2'd1, 0, 0, 1, 1, "R5 R8 demux move flagged");
        step(1, 2'd1, 1, 1, 0, 0, "R6 hold after demux");
        step(1, 2'd3, 0, 1, 1, 0, "R8 R4 write with move");
        step(1, 2'd3, 0, 1, 1, 0, "R8 no move no pulse");
        for (int i = 0; i < 4; i++)
            step(1, i[1:0], 0, 1, i[0], ~i[0], "R3 R8 walk write");
        step(1, 2'd3, 1, 1, 0, 0, "R6 final hold");
        step(0, 2'd3, 1, 1, 0, 0, "R1 reset mid-run");
        step(1, 2'd2, 0, 1, 1, 1, "R9 first edge after reset");
        step(1, 2'd2, 1, 1, 0, 0, "R6 closing hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule